// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block drives and senses a parameterised set of general-purpose pins (94 by default) and turns input activity into a single interrupt line. Software reaches it through a plain 32-bit register port: an address, a write strobe, write data and a read data bus that answers one cycle after the address. Each pin owns two configuration words. They set whether the pin is handed to the controller or left to its native function, whether it drives or senses, the level it drives, whether its input is sensed at all, a stored weak-pull code, and the kind of event that raises its interrupt.

Three families of bitmap words hold 32 pins each. One is a read-only ownership map fixed by a parameter. One holds latched interrupt status. One holds interrupt enables. A pin counts as pending when its status and enable bits are both 1. The OR of all pending pins, delayed by one register, drives the interrupt output. Pad inputs pass through a two-flop synchroniser before they are used. Addresses are byte offsets and must be word aligned, so a misaligned address decodes as unmapped. The bitmap layout limits the block to at most 128 pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset:
  - every pin's first configuration word reads 0x00000005 (input, controller-owned, output level 0) while its pad is low;
  - every second word reads 0;
  - all status and enable bits are 0;
  - `irq` is 0 and no `pad_oe` bit is set.
- R2: For each pin, `pad_oe` is 1 only when word-1 bit 0 is 1 and word-1 bit 2 is 0, and `pad_out` equals word-1 bit 31. Both take effect the cycle after the write.
- R3: Word-1 bit 30 reads the pad level after a two-flop synchroniser. It reads 0 while word-2 bit 2 (sensing off) is set.
- R4: With word-1 bits {4,3} = 00, a rising pad edge sets the pin's status bit once. With {4,3} = 01, a falling edge sets it once. The opposite edge sets nothing.
- R5: With {4,3} = 10, a low pad sets the status bit on every cycle it holds, and with 11 a high pad does the same. A clear written while the condition holds has no lasting effect.
- R6: Writing to a status word clears each bit whose write-data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears the whole bank.
- R7: When a pin's event and a clear of the same status bit fall in the same cycle, the bit ends set.
- R8: `irq` equals the OR over all pins of (status AND enable) as it stood one cycle earlier.
- R9: Bank b of the bitmap words sits at the following byte offsets, bit i standing for pin 32*b+i:
  - ownership: 0x00+4b, read-only, returning `OWNER_MAP`;
  - status: 0x80+4b;
  - enable: 0x90+4b, read/write.
- R10: Read data appears one cycle after the address. Unmapped or misaligned addresses read as 0, and writes to them change nothing.
- R11: Pin p's word 1 is at 0x100+8p and its word 2 at 0x104+8p:
  - word 1 stores bits 31, 4, 3, 2 and 0;
  - word 2 stores bit 2 and bits 1:0, and bits 1:0 only read back;
  - a write to one pin does not alter its neighbours.
- R12: While sensing is off, pad activity latches no event, and turning sensing back on latches no event by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Level driven to each pad |
| pad_oe | output | NUM_PINS | Pad driver enable per pin |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a fresh edge event on that pin. The edge must be timed through the two synchroniser stages so that the event and the write-1 strobe are both sampled on the same clock edge. The bench drives the pad on a falling clock edge, waits exactly two falling edges, and then presents the clear, so the outcome shows whether the set or the clear wins. Level-mode clears that do not stick, and the one-cycle lag of `irq` after an enable write, are also sampled at fixed cycle offsets. Randomised configuration writes and pad patterns cover the readback and the pad drive logic.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    // byte offsets of the register regions
    localparam int unsigned OFS_OWN  = 32'h000;
    localparam int unsigned OFS_STAT = 32'h080;
    localparam int unsigned OFS_EN   = 32'h090;
    localparam int unsigned OFS_CFG  = 32'h100;
    localparam int unsigned BANK_W   = 32;

    // word-1 bit positions
    localparam int unsigned B_OUT  = 31;
    localparam int unsigned B_IN   = 30;
    localparam int unsigned B_TRIG = 4;
    localparam int unsigned B_INV  = 3;
    localparam int unsigned B_DIR  = 2;
    localparam int unsigned B_USE  = 0;
    // word-2 bit positions
    localparam int unsigned B_SOFF = 2;

    typedef struct packed {
        logic out_lvl;
        logic trig_lvl;   // 0 edge, 1 level
        logic inv;
        logic dir_in;     // 1 input, 0 output
        logic use_gpio;   // 1 controller, 0 native
    } word1_t;

    typedef struct packed {
        logic       sense_off;
        logic [1:0] pull;
    } word2_t;

    typedef struct packed {
        word1_t w1;
        word2_t w2;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_w1,
    input  logic        wr_w2,
    input  word1_t      w1_val,
    input  word2_t      w2_val,
    input  logic        pad_i,
    output logic [31:0] w1_rd,
    output logic [31:0] w2_rd,
    output logic        evt,
    output logic        pad_o,
    output logic        pad_en
);

    typedef struct packed {
        pin_cfg_t   cfg;
        logic [1:0] sync;   // sync[1] is the second stage
        logic       prev;
    } cell_t;

    cell_t st_d, st_q;
    logic  lvl_now;
    logic  sensed;
    logic  raw_evt;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pad_i};
        st_d.prev = st_q.sync[1];
        if (wr_w1) st_d.cfg.w1 = w1_val;
        if (wr_w2) st_d.cfg.w2 = w2_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                 <= '0;
            st_q.cfg.w1.dir_in   <= 1'b1;
            st_q.cfg.w1.use_gpio <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_now = st_q.sync[1];
    assign sensed  = lvl_now & ~st_q.cfg.w2.sense_off;

    always_comb begin
        unique case ({st_q.cfg.w1.trig_lvl, st_q.cfg.w1.inv})
            2'b00:   raw_evt = lvl_now & ~st_q.prev;
            2'b01:   raw_evt = ~lvl_now & st_q.prev;
            2'b10:   raw_evt = ~lvl_now;
            default: raw_evt = lvl_now;
        endcase
    end

    assign evt    = raw_evt & ~st_q.cfg.w2.sense_off;
    assign pad_o  = st_q.cfg.w1.out_lvl;
    assign pad_en = st_q.cfg.w1.use_gpio & ~st_q.cfg.w1.dir_in;

    assign w1_rd = {st_q.cfg.w1.out_lvl, sensed, 25'b0, st_q.cfg.w1.trig_lvl,
                    st_q.cfg.w1.inv, st_q.cfg.w1.dir_in, 1'b0, st_q.cfg.w1.use_gpio};
    assign w2_rd = {29'b0, st_q.cfg.w2.sense_off, st_q.cfg.w2.pull};

    // R2: a controller-owned output write enables the driver next cycle
    a_r2_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1 && w1_val.use_gpio && !w1_val.dir_in |=> pad_en);

    // R2: handing the pin to its native function releases the driver
    a_r2_native_release: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1 && !w1_val.use_gpio |=> !pad_en);

    // R12 / R3: switching sensing off silences events and the level bit
    a_r12_muted: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w2 && w2_val.sense_off |=> !evt && !w1_rd[B_IN]);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int unsigned NUM_PINS  = 94,
    parameter int unsigned NUM_BANKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  set_vec,
    input  logic [NUM_BANKS-1:0] stat_wr,
    input  logic [NUM_BANKS-1:0] en_wr,
    input  logic [31:0]          wdata,
    output logic [NUM_PINS-1:0]  status,
    output logic [NUM_PINS-1:0]  enable,
    output logic                 irq
);

    typedef struct packed {
        logic [NUM_PINS-1:0] stat;
        logic [NUM_PINS-1:0] en;
        logic                irq;
    } bank_t;

    bank_t               st_d, st_q;
    logic [NUM_PINS-1:0] clr_hit;
    logic [NUM_PINS-1:0] en_next;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        localparam int unsigned BK = p / 32;
        localparam int unsigned BT = p % 32;
        assign clr_hit[p] = stat_wr[BK] & wdata[BT];
        assign en_next[p] = en_wr[BK] ? wdata[BT] : st_q.en[p];
    end

    always_comb begin
        st_d      = st_q;
        // set is merged after the clear so a same-cycle event survives
        st_d.stat = (st_q.stat & ~clr_hit) | set_vec;
        st_d.en   = en_next;
        st_d.irq  = |(st_q.stat & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;
    assign enable = st_q.en;
    assign irq    = st_q.irq;

    // R7: every event bit is present after the edge, whatever was written
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R6: a cleared bit with no competing event reads 0 next cycle
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_hit) |=> ((status & $past(clr_hit & ~set_vec)) == '0));

    // R8: the output lags the pending OR by one cycle
    a_r8_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(status & enable)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned         NUM_PINS  = 94,
    parameter int unsigned         ADDR_W    = 12,
    parameter logic [NUM_PINS-1:0] OWNER_MAP = {NUM_PINS{1'b1}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam int unsigned NB   = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int unsigned PADW = NB * BANK_W;
    localparam logic [PADW-1:0] OWN_PAD = PADW'(OWNER_MAP);

    typedef struct packed {
        logic [31:0] rdata;
    } top_t;

    top_t st_d, st_q;

    logic [NB-1:0]       own_hit, stat_hit, en_hit;
    logic [NUM_PINS-1:0] w1_hit, w2_hit, evt;
    logic [NUM_PINS-1:0] status, enable;
    logic [PADW-1:0]     stat_pad, en_pad;
    logic [31:0]         w1_rd [NUM_PINS];
    logic [31:0]         w2_rd [NUM_PINS];
    logic                any_hit;
    word1_t              w1_val;
    word2_t              w2_val;

    // write data split into the stored fields
    assign w1_val = '{out_lvl:  bus_wdata[B_OUT],  trig_lvl: bus_wdata[B_TRIG],
                      inv:      bus_wdata[B_INV],  dir_in:   bus_wdata[B_DIR],
                      use_gpio: bus_wdata[B_USE]};
    assign w2_val = '{sense_off: bus_wdata[B_SOFF], pull: bus_wdata[1:0]};

    for (genvar b = 0; b < NB; b++) begin : g_bank_dec
        assign own_hit[b]  = bus_addr == ADDR_W'(OFS_OWN  + 4 * b);
        assign stat_hit[b] = bus_addr == ADDR_W'(OFS_STAT + 4 * b);
        assign en_hit[b]   = bus_addr == ADDR_W'(OFS_EN   + 4 * b);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign w1_hit[p] = bus_addr == ADDR_W'(OFS_CFG + 8 * p);
        assign w2_hit[p] = bus_addr == ADDR_W'(OFS_CFG + 8 * p + 4);

        gpio_pin_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_w1  (bus_we & w1_hit[p]),
            .wr_w2  (bus_we & w2_hit[p]),
            .w1_val (w1_val),
            .w2_val (w2_val),
            .pad_i  (pad_in[p]),
            .w1_rd  (w1_rd[p]),
            .w2_rd  (w2_rd[p]),
            .evt    (evt[p]),
            .pad_o  (pad_out[p]),
            .pad_en (pad_oe[p])
        );
    end

    gpio_irq_bank #(
        .NUM_PINS  (NUM_PINS),
        .NUM_BANKS (NB)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt),
        .stat_wr (stat_hit & {NB{bus_we}}),
        .en_wr   (en_hit & {NB{bus_we}}),
        .wdata   (bus_wdata),
        .status  (status),
        .enable  (enable),
        .irq     (irq)
    );

    assign stat_pad = PADW'(status);
    assign en_pad   = PADW'(enable);
    assign any_hit  = |{own_hit, stat_hit, en_hit, w1_hit, w2_hit};

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        for (int b = 0; b < NB; b++) begin
            st_d.rdata |= {32{own_hit[b]}}  & OWN_PAD[b*32 +: 32];
            st_d.rdata |= {32{stat_hit[b]}} & stat_pad[b*32 +: 32];
            st_d.rdata |= {32{en_hit[b]}}   & en_pad[b*32 +: 32];
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            st_d.rdata |= ({32{w1_hit[p]}} & w1_rd[p]) | ({32{w2_hit[p]}} & w2_rd[p]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R10: an address that decodes to nothing returns zero a cycle later
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> bus_rdata == 32'h0);

    // R1: with no enable set, the interrupt stays low
    a_r1_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        enable == '0 |=> !irq);

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    localparam int N = 94;
    localparam logic [N-1:0] OWN = ~((94'd1 << 5) | (94'd1 << 70));
    localparam int P = 37;                 // bank 1, bit 5
    localparam logic [11:0] STAT1 = 12'h084;
    localparam logic [11:0] EN1   = 12'h094;
    localparam logic [31:0] PBIT  = 32'h20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [11:0]   addr;
    logic          we;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [N-1:0]  pad;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(12), .OWNER_MAP(OWN)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pad_in(pad), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [11:0] w1a(input int p);
        return 12'(256 + 8 * p);
    endfunction
    function automatic logic [11:0] w2a(input int p);
        return 12'(260 + 8 * p);
    endfunction
    function automatic logic [31:0] exp_w1(input logic [31:0] w, input logic lvl);
        return (w & 32'h8000001D) | (32'(lvl) << 30);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; we = 1'b0;
        @(negedge clk); d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pad(input int p, input logic v);
        @(negedge clk); pad[p] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; pad = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 pad_oe", 32'(pad_oe != '0), 0);
        rd(w1a(0), d);  chk("R1 word1", d, 32'h5);
        rd(w2a(0), d);  chk("R1 word2", d, 0);
        rd(12'h080, d); chk("R1 status", d, 0);
        rd(12'h094, d); chk("R1 enable", d, 0);

        // R9 ownership map, read-only
        rd(12'h000, d); chk("R9 own bank0", d, OWN[31:0]);
        rd(12'h008, d); chk("R9 own bank2", d, {2'b0, OWN[93:64]});
        wr(12'h000, 32'h0);
        rd(12'h000, d); chk("R9 own after write", d, OWN[31:0]);

        // R10 unmapped / misaligned
        rd(12'h07C, d); chk("R10 gap", d, 0);
        wr(12'h3F0, 32'hFFFF_FFFF);
        rd(12'h3F0, d); chk("R10 past last pin", d, 0);
        rd(12'h101, d); chk("R10 misaligned", d, 0);

        // R11 word2 storage
        wr(w2a(93), 32'hFFFF_FFFF);
        rd(w2a(93), d); chk("R11 word2 all ones", d, 32'h7);
        wr(w2a(93), 32'h1);
        rd(w2a(93), d); chk("R11 word2 pull", d, 32'h1);
        wr(w2a(93), 32'h0);

        // R2 pad drive, R11 neighbour isolation
        wr(w1a(38), 32'h8000_0001);
        chk("R2 oe on", 32'(pad_oe[38]), 1);
        chk("R2 out level", 32'(pad_out[38]), 1);
        rd(w1a(P), d); chk("R11 neighbour untouched", d, 32'h5);
        wr(w1a(38), 32'h8000_0000);
        chk("R2 native releases", 32'(pad_oe[38]), 0);
        wr(w1a(38), 32'h5);

        // R4 rising edge
        wr(EN1, PBIT);
        set_pad(P, 1'b1); idle(4);
        rd(STAT1, d); chk("R4 rising sets", d, PBIT);
        chk("R8 irq pending", 32'(irq), 1);
        wr(STAT1, PBIT);
        rd(STAT1, d); chk("R6 w1c clears", d, 0);
        idle(1);
        chk("R8 irq drops", 32'(irq), 0);
        set_pad(P, 1'b0); idle(4);
        rd(STAT1, d); chk("R4 falling ignored in rising mode", d, 0);

        // R4 falling edge
        wr(w1a(P), 32'hD);
        set_pad(P, 1'b1); idle(4);
        rd(STAT1, d); chk("R4 rising ignored in falling mode", d, 0);
        set_pad(P, 1'b0); idle(4);
        rd(STAT1, d); chk("R4 falling sets", d, PBIT);
        wr(STAT1, PBIT); idle(4);
        rd(STAT1, d); chk("R4 edge sets once", d, 0);

        // R5 level high
        wr(w1a(P), 32'h1D);
        rd(STAT1, d); chk("R5 high idle low", d, 0);
        set_pad(P, 1'b1); idle(4);
        wr(STAT1, PBIT);
        rd(STAT1, d); chk("R5 high clear does not stick", d, PBIT);
        set_pad(P, 1'b0); idle(4);
        wr(STAT1, PBIT);
        rd(STAT1, d); chk("R5 high clears after release", d, 0);

        // R5 level low
        wr(w1a(P), 32'h15); idle(2);
        rd(STAT1, d); chk("R5 low sets", d, PBIT);
        set_pad(P, 1'b1); idle(4);
        wr(STAT1, PBIT);
        rd(STAT1, d); chk("R5 low clears after release", d, 0);
        wr(w1a(P), 32'h5);
        set_pad(P, 1'b0); idle(4);

        // R6 write of 0 and whole-bank clear
        set_pad(P, 1'b1); idle(4);
        wr(STAT1, 32'h0);
        rd(STAT1, d); chk("R6 zero write keeps", d, PBIT);
        wr(STAT1, 32'hFFFF_FFFF);
        rd(STAT1, d); chk("R6 bank clear", d, 0);

        // R8 enable gating and lag
        set_pad(P, 1'b0); idle(4);
        set_pad(P, 1'b1); idle(4);
        wr(EN1, 32'h0); idle(2);
        chk("R8 masked", 32'(irq), 0);
        wr(EN1, PBIT);
        chk("R8 lag one cycle", 32'(irq), 0);
        @(negedge clk);
        chk("R8 rises", 32'(irq), 1);
        rd(EN1, d); chk("R9 enable readback", d, PBIT);
        wr(STAT1, PBIT);

        // R12 / R3 sensing off
        set_pad(P, 1'b0); idle(4);
        wr(w2a(P), 32'h4);
        set_pad(P, 1'b1); idle(4);
        rd(STAT1, d); chk("R12 no event while muted", d, 0);
        rd(w1a(P), d); chk("R3 level reads 0 while muted", d, 32'h5);
        wr(w2a(P), 32'h0); idle(1);
        rd(w1a(P), d); chk("R3 level visible", d, 32'h4000_0005);
        rd(STAT1, d); chk("R12 no event on unmute", d, 0);

        // R7 set wins over same-cycle clear
        set_pad(P, 1'b0); idle(4);
        @(negedge clk); pad[P] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = STAT1; wdata = PBIT; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(STAT1, d); chk("R7 set beats clear", d, PBIT);
        wr(STAT1, 32'hFFFF_FFFF);

        // R2 / R11 random configuration
        for (int i = 0; i < 30; i++) begin
            int p;
            logic [31:0] w;
            p = int'($urandom_range(93, 0));
            w = $urandom() & ~32'h10;
            wr(w1a(p), w);
            chk("R2 random oe", 32'(pad_oe[p]), 32'(w[0] & ~w[2]));
            chk("R2 random out", 32'(pad_out[p]), 32'(w[31]));
            rd(w1a(p), d); chk("R11 random word1", d, exp_w1(w, pad[p]));
        end

        // R3 random pad levels
        @(negedge clk); pad = N'({$urandom(), $urandom(), $urandom()});
        idle(4);
        for (int i = 0; i < 10; i++) begin
            int p;
            p = int'($urandom_range(93, 0));
            rd(w1a(p), d); chk("R3 random level", 32'(d[30]), 32'(pad[p]));
        end

        report();
    end

endmodule